// File: doc/BRIEF.md
# Segmented Packet Bus Ingress Adapter

This block sits at the entry of a transmit path. A packet source presents packets as a sequence of 128-bit words on a local bus. Every bus input is qualified by an enable. A start marker opens a packet, an end marker closes it, and on the closing word a 4-bit empty count says how many trailing byte lanes carry no data. An error input on the closing word marks the whole packet as bad.

Each enabled input word becomes one registered output beat, one clock later. An output beat carries:

- the data, with packet byte 0 in bits [127:120];
- a 16-bit byte-valid mask;
- start and end markers;
- a bad-packet flag.

When a packet is marked bad, its final word is replaced by a fixed error character in every byte. A sticky violation output reports source behaviour that breaks the bus rules. Only a synchronous reset clears it.

Top module: `pkt_ingress_adapter`

## Requirements
- R1: After a synchronous active-high reset, `out_vld`, `out_sop`, `out_eop`, `out_bad`, `out_keep` and `out_viol` are all zero, and no packet is open.
- R2: `out_vld` equals the value `in_en` had one cycle earlier. On a cycle with `in_en` low, the next beat has `out_sop`, `out_eop`, `out_bad` and `out_keep` at zero. The other inputs of that cycle also have no effect on the packet-open state or on `out_viol`.
- R3: On an enabled word that is not an errored end, `out_data` is `in_data` unchanged one cycle later: packet byte 0 in bits [127:120], byte 15 in bits [7:0]. `out_sop` and `out_eop` copy `in_sop` and `in_eop`.
- R4: On an end word without error, mask bit j covers `out_data[8j+7:8j]`. Bit j is 0 for j < `in_mty` and 1 otherwise. So `in_mty`=0 gives all ones, and `in_mty`=15 leaves only bit 15 set.
- R5: Every valid beat that is not an end beat has all 16 mask bits set.
- R6: An end word with `in_err` high produces a beat with every data byte equal to 0xFE, the mask all ones and `out_bad` set. `in_mty` is ignored on such a word.
- R7: A word with both `in_sop` and `in_eop` high is a complete single-word packet. It is legal and leaves no packet open.
- R8: An enabled start while a packet is open sets `out_viol`. The new start then opens a fresh packet.
- R9: An enabled word without start while no packet is open sets `out_viol`. This includes a stray end.
- R10: An enabled word with `in_err` high and `in_eop` low sets `out_viol`.
- R11: An enabled word with `in_eop` low and a non-zero `in_mty` sets `out_viol`.
- R12: `out_viol` rises on the beat after the offending word. It stays high until reset, whatever traffic follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_en | input | 1 | Qualifies all other inputs this cycle |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_mty | input | 4 | Empty byte lanes at the low end of a last word |
| in_err | input | 1 | Marks the packet bad (with in_eop) |
| in_data | input | 128 | Packet data, byte 0 in the top bits |
| out_vld | output | 1 | Output beat valid |
| out_sop | output | 1 | Beat starts a packet |
| out_eop | output | 1 | Beat ends a packet |
| out_bad | output | 1 | Beat is the substituted end of a bad packet |
| out_data | output | 128 | Beat data |
| out_keep | output | 16 | Byte-valid mask, bit j covers data bits [8j+7:8j] |
| out_viol | output | 1 | Sticky protocol violation flag |

## Verification
The only hidden state is the packet-open bit. If that bit is wrong, the adapter misjudges a start or a continuation word. `out_viol` then rises on the beat right after that word, or fails to rise when it should. The bench therefore replays packet sequences, idle gaps carrying garbage, and each kind of violation against a behavioural model, comparing every output on every clock. Mask decoding and error substitution have no memory, so a fault there shows on the very beat that carries the end word.

// File: rtl/pkt_ingress_adapter.sv
module pkt_ingress_adapter #(
  parameter int DATA_W = 128,
  parameter logic [7:0] ERR_CHAR = 8'hFE,
  localparam int BYTES = DATA_W / 8,
  localparam int MTY_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_en,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [MTY_W-1:0]  in_mty,
  input  logic              in_err,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_bad,
  output logic [DATA_W-1:0] out_data,
  output logic [BYTES-1:0]  out_keep,
  output logic              out_viol
);

  localparam logic [BYTES-1:0] ALL_LANES = '1;

  logic              pkt_open;
  logic              bad_end;
  logic [BYTES-1:0]  tail_keep;
  logic [BYTES-1:0]  keep_nxt;
  logic [DATA_W-1:0] data_nxt;
  logic              open_nxt;
  logic              viol_now;

  assign bad_end   = in_eop & in_err;
  assign tail_keep = ALL_LANES << in_mty;
  assign keep_nxt  = (in_eop && !in_err) ? tail_keep : ALL_LANES;
  assign data_nxt  = bad_end ? {BYTES{ERR_CHAR}} : in_data;
  assign open_nxt  = in_sop ? ~in_eop : (in_eop ? 1'b0 : pkt_open);

  assign viol_now = in_en & ((in_sop & pkt_open) |
                             (~in_sop & ~pkt_open) |
                             (in_err & ~in_eop) |
                             (~in_eop & (|in_mty)));

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_open <= 1'b0;
      out_vld  <= 1'b0;
      out_sop  <= 1'b0;
      out_eop  <= 1'b0;
      out_bad  <= 1'b0;
      out_data <= '0;
      out_keep <= '0;
      out_viol <= 1'b0;
    end else begin
      out_vld  <= in_en;
      out_viol <= out_viol | viol_now;
      if (in_en) begin
        pkt_open <= open_nxt;
        out_sop  <= in_sop;
        out_eop  <= in_eop;
        out_bad  <= bad_end;
        out_data <= data_nxt;
        out_keep <= keep_nxt;
      end else begin
        out_sop  <= 1'b0;
        out_eop  <= 1'b0;
        out_bad  <= 1'b0;
        out_keep <= '0;
      end
    end
  end

endmodule

// File: rtl/pkt_ingress_adapter_chk.sv
module pkt_ingress_adapter_chk #(
  parameter int BYTES = 16,
  parameter int MTY_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               in_en,
  input logic               in_eop,
  input logic [MTY_W-1:0]   in_mty,
  input logic               in_err,
  input logic               out_vld,
  input logic               out_sop,
  input logic               out_eop,
  input logic               out_bad,
  input logic [BYTES*8-1:0] out_data,
  input logic [BYTES-1:0]   out_keep,
  input logic               out_viol
);

  p_vld_follows_en_r2: assert property (@(posedge clk) disable iff (rst)
    in_en |=> out_vld);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !in_en |=> (!out_vld && !out_sop && !out_eop && !out_bad && out_keep == '0));

  p_top_lane_kept_r4: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> out_keep[BYTES-1]);

  p_full_mask_r5: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_eop) |-> (&out_keep));

  p_bad_beat_r6: assert property (@(posedge clk) disable iff (rst)
    out_bad |-> (out_eop && (&out_keep) && out_data == {BYTES{8'hFE}}));

  p_err_no_eop_r10: assert property (@(posedge clk) disable iff (rst)
    (in_en && in_err && !in_eop) |=> out_viol);

  p_mty_midpkt_r11: assert property (@(posedge clk) disable iff (rst)
    (in_en && !in_eop && in_mty != '0) |=> out_viol);

  p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    out_viol |=> out_viol);

endmodule

bind pkt_ingress_adapter pkt_ingress_adapter_chk #(.BYTES(BYTES), .MTY_W(MTY_W)) u_chk (
  .clk(clk), .rst(rst), .in_en(in_en), .in_eop(in_eop), .in_mty(in_mty),
  .in_err(in_err), .out_vld(out_vld), .out_sop(out_sop), .out_eop(out_eop),
  .out_bad(out_bad), .out_data(out_data), .out_keep(out_keep), .out_viol(out_viol)
);

// File: tb/pkt_ingress_adapter_test.sv
`timescale 1ns/1ps
module pkt_ingress_adapter_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_en = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
  logic [3:0]   in_mty = '0;
  logic [127:0] in_data = '0;
  logic         out_vld, out_sop, out_eop, out_bad, out_viol;
  logic [127:0] out_data;
  logic [15:0]  out_keep;

  always #5 clk = ~clk;

  pkt_ingress_adapter uut (
    .clk(clk), .rst(rst), .in_en(in_en), .in_sop(in_sop), .in_eop(in_eop),
    .in_mty(in_mty), .in_err(in_err), .in_data(in_data),
    .out_vld(out_vld), .out_sop(out_sop), .out_eop(out_eop), .out_bad(out_bad),
    .out_data(out_data), .out_keep(out_keep), .out_viol(out_viol)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference model
  bit           armed = 0;
  bit           m_open;
  logic         e_vld, e_sop, e_eop, e_bad, e_viol;
  logic [127:0] e_data;
  logic [15:0]  e_keep;
  string        dtag = "R3", ktag = "R5", vtag = "R12";

  always @(posedge clk) begin
    armed = 1;
    if (rst) begin
      m_open = 0; e_vld = 0; e_sop = 0; e_eop = 0; e_bad = 0;
      e_data = '0; e_keep = '0; e_viol = 0; vtag = "R12";
    end else begin
      e_vld = in_en;
      if (in_en) begin
        string why;
        why = "";
        if (in_sop && m_open) why = "R8";
        else if (!in_sop && !m_open) why = "R9";
        else if (in_err && !in_eop) why = "R10";
        else if (!in_eop && in_mty != 0) why = "R11";
        if (in_err && !in_eop && why == "") why = "R10";
        if (why != "" && !e_viol) begin e_viol = 1; vtag = why; end
        if (in_sop) m_open = !in_eop;
        else if (in_eop) m_open = 0;
        e_sop = in_sop; e_eop = in_eop;
        e_bad = in_eop && in_err;
        if (e_bad) begin
          for (int b = 0; b < 16; b++) e_data[b*8 +: 8] = 8'hFE;
          e_keep = 16'hFFFF; dtag = "R6"; ktag = "R6";
        end else begin
          e_data = in_data; dtag = "R3";
          if (in_eop) begin
            for (int j = 0; j < 16; j++) e_keep[j] = (j >= int'(in_mty));
            ktag = "R4";
          end else begin
            e_keep = 16'hFFFF; ktag = "R5";
          end
        end
      end else begin
        e_sop = 0; e_eop = 0; e_bad = 0; e_keep = '0; ktag = "R2";
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk(out_vld === e_vld, "R2", 128'(out_vld), 128'(e_vld));
      chk(out_sop === e_sop && out_eop === e_eop, "R3",
          128'({out_sop, out_eop}), 128'({e_sop, e_eop}));
      chk(out_bad === e_bad, "R6", 128'(out_bad), 128'(e_bad));
      chk(out_data === e_data, dtag, out_data, e_data);
      chk(out_keep === e_keep, ktag, 128'(out_keep), 128'(e_keep));
      chk(out_viol === e_viol, vtag, 128'(out_viol), 128'(e_viol));
    end
  end

  task automatic beat(input bit en, input bit sop, input bit eop,
                      input logic [3:0] mty, input bit err);
    @(negedge clk);
    in_en = en; in_sop = sop; in_eop = eop; in_mty = mty; in_err = err;
    in_data = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(0, 0, 0, 0, 0);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1; in_en = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(out_vld === 0 && out_keep === 0 && out_viol === 0 && out_bad === 0,
        "R1", 128'({out_vld, out_keep, out_viol}), 128'(0));

    // three-word packet, 5 empty lanes at end
    beat(1, 1, 0, 0, 0); beat(1, 0, 0, 0, 0); beat(1, 0, 1, 5, 0);
    idle(1);
    chk(out_keep === 16'hFFE0, "R4", 128'(out_keep), 128'(16'hFFE0));
    idle(1);
    // gap with garbage inside a packet must be ignored
    beat(1, 1, 0, 0, 0);
    beat(0, 1, 1, 7, 1);
    beat(0, 0, 0, 9, 1);
    chk(out_vld === 0 && out_sop === 0 && out_keep === 0, "R2",
        128'({out_vld, out_sop, out_keep}), 128'(0));
    beat(1, 0, 0, 0, 0); beat(1, 0, 1, 0, 0);
    idle(1);
    chk(out_viol === 0, "R2", 128'(out_viol), 128'(0));

    // single-word packets over every empty count
    for (int m = 0; m < 16; m++) beat(1, 1, 1, 4'(m), 0);
    idle(1);
    chk(out_sop === 1 && out_eop === 1 && out_keep === 16'h8000 && out_viol === 0,
        "R7", 128'({out_sop, out_eop, out_keep, out_viol}), 128'({1'b1, 1'b1, 16'h8000, 1'b0}));

    // errored packets: multi-word and single-word, mty ignored
    beat(1, 1, 0, 0, 0); beat(1, 0, 1, 9, 1);
    idle(1);
    chk(out_bad === 1 && out_data === {16{8'hFE}} && out_keep === 16'hFFFF, "R6",
        out_data, {16{8'hFE}});
    beat(1, 1, 1, 3, 1);
    beat(0, 0, 0, 0, 0);
    idle(2);
    chk(out_viol === 0, "R7", 128'(out_viol), 128'(0));

    // R8: start while open
    beat(1, 1, 0, 0, 0); beat(1, 1, 0, 0, 0); beat(1, 0, 1, 0, 0);
    idle(3);
    chk(out_viol === 1, "R12", 128'(out_viol), 128'(1));
    do_reset(); idle(1);
    chk(out_viol === 0, "R1", 128'(out_viol), 128'(0));

    // R9: stray end, then stray data
    beat(1, 0, 1, 0, 0); idle(2);
    do_reset(); beat(1, 0, 0, 0, 0); idle(2);
    do_reset();

    // R10: error without end, mid packet
    beat(1, 1, 0, 0, 0); beat(1, 0, 0, 0, 1); beat(1, 0, 1, 0, 0); idle(2);
    do_reset();

    // R11: non-zero empty on non-final word
    beat(1, 1, 0, 2, 0); beat(1, 0, 1, 0, 0);
    for (int k = 0; k < 4; k++) begin beat(1, 1, 1, 0, 0); end
    idle(2);
    chk(out_viol === 1, "R12", 128'(out_viol), 128'(1));
    do_reset(); idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule